// File: doc/BRIEF.md
# Synchronised Strobe Write Qualifier

This block sits in front of a byte-wide nonvolatile memory model and turns three asynchronous active-low bus strobes (chip select, output enable, write enable) into clean synchronous information. Each strobe passes through a multi-flop synchroniser. The block then decodes the bus state into one of four modes and drives a flag that tells the pad logic when the data bus may be driven. Address and data travel through a pipeline of the same depth, so they stay aligned with the strobes.

A write is defined by chip select and write enable both being low while output enable is high and supply power is good. Either strobe may control the cycle. The address is taken in the first synchronised cycle in which both strobes are low, which is the later of the two falling edges. The data is taken in the last cycle before either strobe rises. When the write ends because chip select or write enable rose, and the low window lasted at least `MIN_PULSE` clock cycles, the block emits one single-cycle write event. That event carries the 9-bit address and the 8-bit data. A window that is too short, or a window that is cut off by an inhibit condition, produces no event.

Top module: `strobe_write_qual`

## Requirements
- R1: `mode` is 2'b11 (inhibit) while `supply_low` is high. Otherwise it is 2'b00 (standby) when `chip_sel_n` is high, 2'b01 (read) when `chip_sel_n`=0, `out_en_n`=0 and `wr_en_n`=1, and 2'b10 (write) when `chip_sel_n`=0, `out_en_n`=1 and `wr_en_n`=0. Every other combination with `chip_sel_n` low gives 2'b11. All of these are decoded after the synchroniser.
- R2: `bus_drive` is high exactly when `mode` is read, so it is low whenever chip select or output enable is high.
- R3: Each qualified write window produces exactly one `wr_pulse`, and that pulse is one cycle wide.
- R4: `wr_addr` carries the address seen in the first cycle of the write window, which is the later of the two strobe falls. Address changes later in the window are ignored.
- R5: `wr_data` carries the data seen in the last cycle of the write window, which is just before the earlier of the two strobe rises.
- R6: A write window shorter than `MIN_PULSE` cycles (default 3) yields no event. A window of `MIN_PULSE` cycles or longer yields one event.
- R7: A write window that ends because output enable falls, or because `supply_low` rises, while both strobes are still low, yields no event.
- R8: `wr_addr` and `wr_data` change only in the cycle where `wr_pulse` is high. Between events they hold the last reported values.
- R9: During reset `mode`=2'b00, `bus_drive`=0, `wr_pulse`=0, `wr_addr`=0 and `wr_data`=0.
- R10: `wr_pulse` rises on the (`SYNC_STAGES`+1)th rising clock edge after the strobe rises. With the default of two stages, that is the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Asynchronous chip select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wr_en_n | input | 1 | Asynchronous write enable, active low |
| supply_low | input | 1 | Supply-too-low indication, active high |
| addr_in | input | 9 | Bus address |
| data_in | input | 8 | Bus write data |
| mode | output | 2 | Decoded bus mode |
| bus_drive | output | 1 | Data bus may be driven (read active) |
| wr_pulse | output | 1 | One-cycle qualified write event |
| wr_addr | output | 9 | Address of the last write event |
| wr_data | output | 8 | Data of the last write event |

## Verification
Suppose the window counter or the address/data capture registers held a wrong value. The next strobe release would then either miss its event, emit a spurious one, or report a wrong address or data word. That error appears on `wr_pulse`, `wr_addr` and `wr_data` exactly `SYNC_STAGES`+1 edges after the rise. A stale synchroniser stage would instead shift `mode` and `bus_drive` by whole cycles. Because of this, the bench samples the event in a fixed cycle and checks that the outputs hold their values after windows that were rejected or aborted.

// File: rtl/swq_pkg.sv
package swq_pkg;

    localparam int ADDR_W = 9;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'b00,
        BUS_RD    = 2'b01,
        BUS_WR    = 2'b10,
        BUS_BLOCK = 2'b11
    } bus_mode_e;

    // Synchronised control lines; sel/oe/wr are active low
    typedef struct packed {
        logic sel_n;
        logic oe_n;
        logic wr_n;
        logic low;
    } pins_t;

    localparam pins_t PINS_RESET = '{sel_n: 1'b1, oe_n: 1'b1, wr_n: 1'b1, low: 1'b0};

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_word_t;

    function automatic bus_mode_e decode_mode(pins_t p);
        if (p.low)                  return BUS_BLOCK;
        if (p.sel_n)                return BUS_IDLE;
        if (!p.oe_n && p.wr_n)      return BUS_RD;
        if (p.oe_n && !p.wr_n)      return BUS_WR;
        return BUS_BLOCK;
    endfunction

    // A window ending is honoured only if a strobe rose and nothing inhibits
    function automatic logic release_ok(pins_t p);
        return (p.sel_n || p.wr_n) && p.oe_n && !p.low;
    endfunction

endpackage

// File: rtl/swq_sync.sv
module swq_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= RESET_VAL;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= RESET_VAL;
                    else     stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/swq_mode_decode.sv
module swq_mode_decode
    import swq_pkg::*;
(
    input  pins_t     pins,
    output bus_mode_e mode,
    output logic      drive
);

    always_comb begin
        mode  = decode_mode(pins);
        drive = (mode == BUS_RD);
    end

endmodule

// File: rtl/swq_write_qual.sv
module swq_write_qual
    import swq_pkg::*;
#(
    parameter int MIN_PULSE = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  bus_mode_e mode,
    input  pins_t     pins,
    input  wr_word_t  bus_word,
    output logic      evt,
    output wr_word_t  evt_word
);

    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_PULSE);

    logic          active, active_q;
    logic [CW-1:0] run_cnt;
    wr_word_t      cap;
    logic          window_end, accept;

    always_comb begin
        active     = (mode == BUS_WR);
        window_end = active_q && !active;
        accept     = window_end && (run_cnt >= LIMIT) && release_ok(pins);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            run_cnt  <= '0;
            cap      <= '0;
        end else begin
            active_q <= active;
            if (active) begin
                if (!active_q) begin
                    cap.addr <= bus_word.addr;   // later falling edge
                    run_cnt  <= CW'(1);
                end else if (run_cnt < LIMIT) begin
                    run_cnt  <= run_cnt + CW'(1);
                end
                cap.data <= bus_word.data;       // keeps last in-window value
            end else begin
                run_cnt <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt      <= 1'b0;
            evt_word <= '0;
        end else begin
            evt <= accept;
            if (accept) evt_word <= cap;
        end
    end

endmodule

// File: rtl/strobe_write_qual.sv
module strobe_write_qual
    import swq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PULSE   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_sel_n,
    input  logic              out_en_n,
    input  logic              wr_en_n,
    input  logic              supply_low,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [1:0]        mode,
    output logic              bus_drive,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int PW = $bits(pins_t);
    localparam int WW = $bits(wr_word_t);

    pins_t     raw_pins, s_pins;
    wr_word_t  raw_word, s_word, ev_word;
    bus_mode_e cur_mode;

    assign raw_pins = '{sel_n: chip_sel_n, oe_n: out_en_n, wr_n: wr_en_n, low: supply_low};
    assign raw_word = '{addr: addr_in, data: data_in};

    swq_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES), .RESET_VAL(PINS_RESET)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (s_pins)
    );

    // Same depth as the strobes so the bus word stays aligned with them
    swq_sync #(.WIDTH(WW), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_word_pipe (
        .clk (clk),
        .rst (rst),
        .d   (raw_word),
        .q   (s_word)
    );

    swq_mode_decode u_decode (
        .pins  (s_pins),
        .mode  (cur_mode),
        .drive (bus_drive)
    );

    swq_write_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .mode     (cur_mode),
        .pins     (s_pins),
        .bus_word (s_word),
        .evt      (wr_pulse),
        .evt_word (ev_word)
    );

    assign mode    = cur_mode;
    assign wr_addr = ev_word.addr;
    assign wr_data = ev_word.data;

endmodule

// File: rtl/swq_checker.sv
module swq_checker
    import swq_pkg::*;
#(
    parameter int MIN_PULSE = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic              bus_drive,
    input logic              wr_pulse,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);

    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_PULSE);

    logic [CW-1:0] run, last_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= '0;
            last_run <= '0;
        end else begin
            if (mode == BUS_WR) begin
                if (run < LIMIT) run <= run + CW'(1);
            end else begin
                run <= '0;
                if (run != '0) last_run <= run;
            end
        end
    end

    a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);

    a_r3_follows_write: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> $past(mode, 2) == BUS_WR);

    a_r6_min_width: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> last_run >= LIMIT);

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_pulse |-> ($stable(wr_addr) && $stable(wr_data)));

    a_r2_idle_undriven: assert property (@(posedge clk) disable iff (rst)
        (mode == BUS_IDLE || mode == BUS_WR) |-> !bus_drive);

endmodule

bind strobe_write_qual swq_checker #(.MIN_PULSE(MIN_PULSE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .bus_drive (bus_drive),
    .wr_pulse  (wr_pulse),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
);

// File: tb/sim_strobe_write_qual.sv
`timescale 1ns/1ps
module sim_strobe_write_qual;

    localparam int MINP = 3;
    localparam int LAT  = 3;   // SYNC_STAGES + 1

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chip_sel_n = 1'b1, out_en_n = 1'b1, wr_en_n = 1'b1, supply_low = 1'b0;
    logic [8:0] addr_in = '0;
    logic [7:0] data_in = '0;
    logic [1:0] mode;
    logic       bus_drive, wr_pulse;
    logic [8:0] wr_addr;
    logic [7:0] wr_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [8:0] last_a = '0;
    logic [7:0] last_d = '0;

    always #5 clk = ~clk;

    strobe_write_qual #(.SYNC_STAGES(2), .MIN_PULSE(MINP)) u0 (
        .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
        .wr_en_n(wr_en_n), .supply_low(supply_low), .addr_in(addr_in),
        .data_in(data_in), .mode(mode), .bus_drive(bus_drive),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_mode(input bit s, input bit o, input bit w, input bit lo);
        if (lo) return 2'b11;
        case ({s, o, w})
            3'b001:  return 2'b01;
            3'b010:  return 2'b10;
            3'b100, 3'b101, 3'b110, 3'b111: return 2'b00;
            default: return 2'b11;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        chip_sel_n = 1'b1; out_en_n = 1'b1; wr_en_n = 1'b1; supply_low = 1'b0;
        addr_in = '0; data_in = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        last_a = '0; last_d = '0;
    endtask

    // abort: 0 strobe release, 1 output enable falls, 2 supply goes low
    task automatic run_write(input bit sel_last, input int low_cyc,
                             input logic [8:0] a_early, input logic [8:0] a_late,
                             input logic [7:0] d_mid, input logic [7:0] d_last,
                             input int abort);
        int got = 0;
        int lat = 0;
        logic [8:0] ga = '0;
        logic [7:0] gd = '0;
        bit exp_evt;
        logic [7:0] exp_d;
        @(negedge clk);
        addr_in = a_early;
        if (sel_last) wr_en_n = 1'b0; else chip_sel_n = 1'b0;
        repeat (2) @(negedge clk);
        addr_in = a_late; data_in = d_mid;
        if (sel_last) chip_sel_n = 1'b0; else wr_en_n = 1'b0;
        for (int j = 1; j < low_cyc; j++) begin
            @(negedge clk);
            addr_in = 9'($urandom);
            if (j == low_cyc - 1) data_in = d_last;
        end
        @(negedge clk);
        data_in = 8'($urandom);
        addr_in = 9'($urandom);
        if (abort == 1)      out_en_n = 1'b0;
        else if (abort == 2) supply_low = 1'b1;
        else if (sel_last)   chip_sel_n = 1'b1;   // first to fall back is the last-falling one
        else                 wr_en_n = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (i == 1) begin
                chip_sel_n = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b1; supply_low = 1'b0;
            end
            if (wr_pulse) begin
                got++; lat = i; ga = wr_addr; gd = wr_data;
            end
        end
        exp_evt = (abort == 0) && (low_cyc >= MINP);
        exp_d   = (low_cyc >= 2) ? d_last : d_mid;
        if (exp_evt) begin
            chk("R3 one event", got, 1);
            chk("R10 latency", lat, LAT);
            chk("R4 address at later fall", ga, a_late);
            chk("R5 data before earlier rise", gd, exp_d);
            last_a = a_late; last_d = exp_d;
        end else begin
            if (abort == 0) chk("R6 short window rejected", got, 0);
            else            chk("R7 inhibited window rejected", got, 0);
            chk("R8 address held", wr_addr, last_a);
            chk("R8 data held", wr_data, last_d);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R9 mode in reset", mode, 2'b00);
        chk("R9 drive in reset", bus_drive, 0);
        chk("R9 pulse in reset", wr_pulse, 0);
        chk("R9 address in reset", wr_addr, 0);
        chk("R9 data in reset", wr_data, 0);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R2: every strobe combination, with and without supply loss
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            chip_sel_n = k[0]; out_en_n = k[1]; wr_en_n = k[2]; supply_low = k[3];
            repeat (3) @(negedge clk);
            chk("R1 mode decode", mode, exp_mode(k[0], k[1], k[2], k[3]));
            chk("R2 drive flag", bus_drive, exp_mode(k[0], k[1], k[2], k[3]) == 2'b01);
        end

        do_reset();

        // Directed corner cases
        run_write(1'b0, MINP - 1, 9'h011, 9'h1A5, 8'h3C, 8'hC3, 0);  // R6 one short
        run_write(1'b0, MINP,     9'h022, 9'h0F0, 8'h11, 8'h5A, 0);  // R6 exact
        run_write(1'b1, MINP,     9'h0AA, 9'h155, 8'h22, 8'hA5, 0);  // R4 select last
        run_write(1'b0, 10,       9'h100, 9'h1FF, 8'h00, 8'hFF, 0);  // long window
        run_write(1'b1, 6,        9'h003, 9'h0C3, 8'h77, 8'h88, 1);  // R7 output enable
        run_write(1'b0, 6,        9'h004, 9'h0C4, 8'h99, 8'h66, 2);  // R7 supply
        run_write(1'b1, 1,        9'h005, 9'h006, 8'h01, 8'h02, 0);  // single cycle

        // Constrained random windows
        for (int r = 0; r < 40; r++) begin
            int ab;
            ab = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 2)) : 0;
            run_write(1'($urandom), int'($urandom_range(1, 7)), 9'($urandom), 9'($urandom),
                      8'($urandom), 8'($urandom), ab);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule